// File: doc/BRIEF.md
# Measurement Command and Ready Controller

This block sequences measurement commands for a sensor peripheral that a host drives over SPI. A one-cycle command strobe, together with a command code, starts a measurement-busy phase. That phase ends when a completion stub signal arrives or when a parameterised number of cycles has passed, whichever comes first. At that point the block raises a data-ready output. After that it counts the result bits the host shifts out on the SPI side, one strobe per bit. It accepts no new command until the whole result has been read or a clear pulse arrives.

A mode input selects how data-ready is cleared. In standard mode an accepted command lowers data-ready by itself. In legacy mode data-ready falls only when the host toggles an external clear pin low-high-low. The clear pin is asynchronous, so it is synchronised inside the block. A clear also aborts any measurement in progress and drops any readout in progress, and it never alters the latched command code. A command that arrives while a measurement is still running replaces the running one and restarts the busy phase. A command that arrives during readout is dropped.

Top module: `meas_ready_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle with `drdy`=0, `busy`=0 and `act_cmd`=0.
- R2: A `cmd_start` pulse in idle is accepted. From the next edge on, `busy`=1 and `act_cmd` holds the `cmd_code` value sampled with the strobe.
- R3: A measurement ends at the earlier of two events: MEAS_CYC (default 20) cycles after the accepting edge, or the edge that samples `meas_done`=1 while busy. At that edge `drdy` becomes 1 and `busy` becomes 0.
- R4: `drdy` rises only at the end of a measurement that was busy in the previous cycle.
- R5: In standard mode (`legacy_mode`=0), an accepted command clears `drdy` at the same edge at which `busy` rises.
- R6: In legacy mode (`legacy_mode`=1), an accepted command leaves `drdy` unchanged. Only a clear pulse lowers it.
- R7: A command while busy replaces `act_cmd`, restarts the busy phase from zero, and never raises `drdy` for the aborted command.
- R8: After `drdy` rises, commands are ignored (`busy` stays 0, `act_cmd` unchanged) until RESULT_BITS (default 16) `shift_strobe` pulses have been counted.
- R9: Once the last result bit has been strobed, the next command is accepted again.
- R10: A clear is a low-high-low toggle of `clear_pin`. Its falling edge takes effect at the third clock edge after the pin falls: it forces `drdy`=0 and `busy`=0 and leaves `act_cmd` unchanged. A pin that is merely held high has no effect.
- R11: A clear during readout ends the readout, so the next command is accepted at once.
- R12: `meas_done` outside a measurement has no effect on `drdy` or `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_start | input | 1 | One-cycle command strobe |
| cmd_code | input | CMD_W | Command code latched with an accepted strobe |
| legacy_mode | input | 1 | 1 = legacy clearing via pin, 0 = standard automatic clearing |
| clear_pin | input | 1 | Asynchronous clear pin, normally low |
| shift_strobe | input | 1 | One pulse per result bit shifted out over SPI |
| meas_done | input | 1 | Measurement-complete stub from the analog side |
| drdy | output | 1 | Data ready |
| busy | output | 1 | Measurement in progress |
| act_cmd | output | CMD_W | Latched command code |

## Verification
The checker watches on every cycle that an accepted command turns on busy and latches its code, that data-ready only rises out of a busy cycle, and that a standard-mode start clears data-ready. It also watches that a legacy-mode start keeps data-ready, that a clear event empties both outputs without touching the code, and that a command during readout starts nothing. Only the bench's scenarios show the measurement latency against the timeout and the done stub, the restart length after an overwrite, and the exact count of sixteen strobes before commands are accepted again. The bench scenarios also cover the three-edge latency of the clear synchroniser and the fact that a held-high pin does nothing.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_READ = 2'd2
  } mrc_state_e;

  // A measurement ends on the stub done or on the final timer count.
  function automatic logic meas_ends(input int unsigned cnt,
                                     input int unsigned limit,
                                     input logic done);
    return done || (cnt == limit - 1);
  endfunction

  // The readout ends with the strobe that carries the last result bit.
  function automatic logic read_ends(input int unsigned cnt,
                                     input int unsigned bits);
    return cnt == bits - 1;
  endfunction

endpackage

// File: rtl/mrc_clr_sync.sv
module mrc_clr_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic fall_evt
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin_async;
      s2 <= s1;
      s3 <= s2;
    end
  end

  // High followed by low completes the low-high-low toggle.
  assign fall_evt = s3 & ~s2;
endmodule

// File: rtl/mrc_meas_timer.sv
module mrc_meas_timer #(
  parameter int unsigned MEAS_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic done_in,
  output logic fin
);
  localparam int unsigned CNT_W = (MEAS_CYC > 2) ? $clog2(MEAS_CYC) : 1;

  logic [CNT_W-1:0] cnt;

  assign fin = run && mrc_pkg::meas_ends(32'(cnt), MEAS_CYC, done_in);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt <= '0;
    end else if (fin) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mrc_readout_ctr.sv
module mrc_readout_ctr #(
  parameter int unsigned RESULT_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  input  logic strobe,
  output logic last
);
  localparam int unsigned BIT_W = (RESULT_BITS > 2) ? $clog2(RESULT_BITS) : 1;

  logic [BIT_W-1:0] cnt;

  assign last = active && strobe && mrc_pkg::read_ends(32'(cnt), RESULT_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt <= '0;
    end else if (last) begin
      cnt <= '0;
    end else if (active && strobe) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/meas_ready_ctrl.sv
module meas_ready_ctrl #(
  parameter int unsigned CMD_W       = 4,
  parameter int unsigned MEAS_CYC    = 20,
  parameter int unsigned RESULT_BITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             legacy_mode,
  input  logic             clear_pin,
  input  logic             shift_strobe,
  input  logic             meas_done,
  output logic             drdy,
  output logic             busy,
  output logic [CMD_W-1:0] act_cmd
);
  import mrc_pkg::*;

  mrc_state_e state;

  // Named internal events, also used by the checker.
  logic clr_evt;
  logic in_meas;
  logic in_readout;
  logic start_acc;
  logic meas_fin;
  logic read_last;

  assign in_meas    = (state == ST_MEAS);
  assign in_readout = (state == ST_READ);
  assign start_acc  = cmd_start && !clr_evt && !in_readout;

  mrc_clr_sync u_clr (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (clear_pin),
    .fall_evt  (clr_evt)
  );

  mrc_meas_timer #(.MEAS_CYC(MEAS_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_acc || clr_evt),
    .run     (in_meas),
    .done_in (meas_done),
    .fin     (meas_fin)
  );

  mrc_readout_ctr #(.RESULT_BITS(RESULT_BITS)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (clr_evt || meas_fin),
    .active  (in_readout),
    .strobe  (shift_strobe),
    .last    (read_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      drdy    <= 1'b0;
      act_cmd <= '0;
    end else if (clr_evt) begin
      state <= ST_IDLE;
      drdy  <= 1'b0;
    end else if (start_acc) begin
      state   <= ST_MEAS;
      act_cmd <= cmd_code;
      if (!legacy_mode) drdy <= 1'b0;
    end else if (meas_fin) begin
      state <= ST_READ;
      drdy  <= 1'b1;
    end else if (read_last) begin
      state <= ST_IDLE;
    end
  end

  assign busy = in_meas;
endmodule

// File: rtl/mrc_checker.sv
module mrc_checker #(
  parameter int unsigned CMD_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic [CMD_W-1:0] cmd_code,
  input logic             legacy_mode,
  input logic             drdy,
  input logic             busy,
  input logic [CMD_W-1:0] act_cmd,
  input logic             start_acc,
  input logic             clr_evt,
  input logic             in_readout
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!drdy && !busy && act_cmd == '0)); // R1
  AST_START_LATCH: assert property (@(posedge clk) disable iff (!rst_n) start_acc |=> (busy && act_cmd == $past(cmd_code))); // R2
  AST_DRDY_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $rose(drdy) |-> $past(busy)); // R4
  AST_STD_AUTOCLEAR: assert property (@(posedge clk) disable iff (!rst_n) (start_acc && !legacy_mode) |=> !drdy); // R5
  AST_LEGACY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (start_acc && legacy_mode && drdy) |=> drdy); // R6
  AST_READOUT_DROP: assert property (@(posedge clk) disable iff (!rst_n) (in_readout && cmd_start) |=> (!busy && $stable(act_cmd))); // R8
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) clr_evt |=> (!drdy && !busy && $stable(act_cmd))); // R10
endmodule

bind meas_ready_ctrl mrc_checker #(.CMD_W(CMD_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_start   (cmd_start),
  .cmd_code    (cmd_code),
  .legacy_mode (legacy_mode),
  .drdy        (drdy),
  .busy        (busy),
  .act_cmd     (act_cmd),
  .start_acc   (start_acc),
  .clr_evt     (clr_evt),
  .in_readout  (in_readout)
);

// File: tb/meas_ready_ctrl_tb_top.sv
`timescale 1ns/100ps
module meas_ready_ctrl_tb_top;
  localparam int unsigned CMD_W = 4;
  localparam int unsigned MEAS_CYC = 20;
  localparam int unsigned RESULT_BITS = 16;

  typedef struct packed {
    logic [3:0] cmd;
    logic       legacy;
    logic [7:0] done_at;  // 255 = never pulse meas_done
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'h3, 1'b0, 8'd255},
    '{4'h5, 1'b1, 8'd255},
    '{4'hA, 1'b0, 8'd0},
    '{4'h6, 1'b1, 8'd7},
    '{4'hC, 1'b0, 8'd19},
    '{4'h9, 1'b0, 8'd30}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [CMD_W-1:0] cmd_code = '0;
  logic legacy_mode = 1'b0;
  logic clear_pin = 1'b0;
  logic shift_strobe = 1'b0;
  logic meas_done = 1'b0;
  logic drdy, busy;
  logic [CMD_W-1:0] act_cmd;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  meas_ready_ctrl #(.CMD_W(CMD_W), .MEAS_CYC(MEAS_CYC), .RESULT_BITS(RESULT_BITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_code(cmd_code),
    .legacy_mode(legacy_mode), .clear_pin(clear_pin), .shift_strobe(shift_strobe),
    .meas_done(meas_done), .drdy(drdy), .busy(busy), .act_cmd(act_cmd)
  );

  // Latency model: the earlier of the stub pulse and the timer limit.
  function automatic int expect_lat(input int done_at);
    if (done_at < int'(MEAS_CYC)) return done_at + 1;
    return int'(MEAS_CYC);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic issue(input logic [CMD_W-1:0] code);
    cmd_code = code;
    cmd_start = 1'b1;
    tick();
    cmd_start = 1'b0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      shift_strobe = 1'b1;
      tick();
      shift_strobe = 1'b0;
      tick();
    end
  endtask

  task automatic clear_toggle();
    clear_pin = 1'b1;
    tick(); tick(); tick();
    clear_pin = 1'b0;
    tick(); tick(); tick();
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    do_reset();
    // R1 reset state
    chk("R1 drdy", drdy, 0);
    chk("R1 busy", busy, 0);
    chk("R1 act_cmd", act_cmd, 0);

    // R12 stray done in idle
    meas_done = 1'b1; tick(); meas_done = 1'b0; tick();
    chk("R12 drdy", drdy, 0);
    chk("R12 busy", busy, 0);

    // Vector table: R2 and R3 latency per mode and stub timing
    foreach (VECS[k]) begin
      int lat;
      do_reset();
      legacy_mode = VECS[k].legacy;
      issue(VECS[k].cmd);
      chk("R2 busy", busy, 1);
      chk("R2 act_cmd", act_cmd, VECS[k].cmd);
      lat = 0;
      while (!drdy && lat < 60) begin
        meas_done = (lat == int'(VECS[k].done_at));
        tick();
        lat++;
      end
      meas_done = 1'b0;
      chk("R3 latency", lat, expect_lat(int'(VECS[k].done_at)));
      chk("R3 busy low", busy, 0);
      strobes(RESULT_BITS);
    end

    // R7 overwrite in standard mode
    do_reset();
    legacy_mode = 1'b0;
    issue(4'h1);
    repeat (10) tick();
    issue(4'h2);
    chk("R7 act_cmd", act_cmd, 2);
    repeat (MEAS_CYC - 1) tick();
    chk("R7 no early drdy", drdy, 0);
    chk("R7 still busy", busy, 1);
    tick();
    chk("R7 drdy after restart", drdy, 1);

    // R8 readout blocks commands
    strobes(8);
    issue(4'h7);
    chk("R8 busy", busy, 0);
    chk("R8 act_cmd", act_cmd, 2);
    chk("R8 drdy", drdy, 1);
    strobes(7);
    issue(4'h7);
    chk("R8 fifteen strobes busy", busy, 0);
    strobes(1);
    // R9 and R5
    issue(4'h8);
    chk("R9 busy", busy, 1);
    chk("R9 act_cmd", act_cmd, 8);
    chk("R5 drdy cleared", drdy, 0);

    // R6 legacy keeps drdy
    do_reset();
    legacy_mode = 1'b1;
    issue(4'h4);
    repeat (MEAS_CYC) tick();
    chk("R6 first drdy", drdy, 1);
    strobes(RESULT_BITS);
    issue(4'hB);
    chk("R6 busy", busy, 1);
    chk("R6 drdy held", drdy, 1);
    repeat (MEAS_CYC) tick();
    strobes(3);

    // R10 held-high pin does nothing, full toggle clears
    clear_pin = 1'b1;
    repeat (5) tick();
    chk("R10 held high", drdy, 1);
    clear_pin = 1'b0;
    tick(); tick();
    chk("R10 before third edge", drdy, 1);
    tick();
    chk("R10 drdy cleared", drdy, 0);
    chk("R10 act_cmd kept", act_cmd, 11);
    // R11 command accepted right after clear
    issue(4'hD);
    chk("R11 busy", busy, 1);

    // R10 clear aborts a measurement
    clear_toggle();
    chk("R10 abort busy", busy, 0);
    repeat (MEAS_CYC + 5) tick();
    chk("R10 abort no drdy", drdy, 0);
    chk("R10 abort act_cmd", act_cmd, 13);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule